// File: doc/BRIEF.md
# DMA Channel Address Sequencer

This block is the address-advance and acknowledge core of a single DMA channel. It keeps one source address and one destination address. Each address can be loaded directly. On every completed transfer, each address either stays where it is, moves up, or moves down, as its own 2-bit mode field selects. The distance it moves follows the transfer unit: one, two, four or sixteen bytes. Both addresses wrap around the top of the address space.

Alongside the addresses, the block drives an acknowledge line toward an external requesting device. In dual address mode, a cycle-select bit decides whether the acknowledge goes out during the read cycle or during the write cycle. In single address mode, it goes out during either cycle. A level bit sets the polarity. Single address mode also names which side is the external device. That side's mode field is ignored and its address does not move.

Illegal settings on a side that is in use raise a sticky error flag, and the flag stops all address movement until software clears it. A side is misconfigured if its mode is the reserved code, or if it uses fixed or decrement with 16-byte units. Every pin is a plain control or status signal. The block carries no data stream, so it has no valid/ready handshake: the transfer-done pulse is a single-cycle event with no back-pressure.

Top module: `dma_addr_seq`

## Requirements
- R1: On a cycle with `xfer_done` high and no error, each side whose address is in use moves according to its mode code. Code 2'b00 holds the address, 2'b01 adds the step and 2'b10 subtracts it. The new value is visible after that clock edge.
- R2: The step is 1, 2, 4 or 16 for `unit_sel` codes 2'b00, 2'b01, 2'b10 and 2'b11 respectively.
- R3: Address arithmetic wraps modulo 2^AW (AW = 32 by default).
- R4: A side that is in use is illegal if its mode is 2'b11, or if `unit_sel` is 2'b11 with mode 2'b00 or 2'b10. Any illegal side sets `cfg_err` at the next clock edge.
- R5: `cfg_err` is sticky. It stays high until a cycle with `err_clr` high and no illegal setting; if both are present, setting wins over clearing.
- R6: No address moves on a `xfer_done` cycle while `cfg_err` is high or an illegal setting is present.
- R7: In single address mode (`single_mode`=1), `ext_on_dst`=1 marks the destination as the external device and 0 marks the source. The external side's mode is ignored, is never judged illegal, and its address is held.
- R8: In dual address mode, the acknowledge is active during `rd_strobe` when `ack_on_write`=0 and during `wr_strobe` when `ack_on_write`=1. It is inactive otherwise.
- R9: In single address mode, the acknowledge is active whenever `rd_strobe` or `wr_strobe` is high, whatever `ack_on_write` says.
- R10: With `ack_high`=0 the active level of `ack` is 0, and with `ack_high`=1 it is 1. While inactive, `ack` sits at the opposite level.
- R11: A load strobe (`src_ld`/`dst_ld`) replaces that address at the next edge and takes priority over a transfer-done update in the same cycle. Loads work even while `cfg_err` is high.
- R12: After reset, both addresses are zero and `cfg_err` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_mode | input | 2 | Source address mode: 00 hold, 01 up, 10 down, 11 reserved |
| dst_mode | input | 2 | Destination address mode, same coding |
| unit_sel | input | 2 | Transfer unit: 00 byte, 01 word, 10 longword, 11 16-byte |
| single_mode | input | 1 | 1 = single address mode, 0 = dual address mode |
| ext_on_dst | input | 1 | Single mode only: 1 = destination is the external device, 0 = source is |
| ack_on_write | input | 1 | Dual mode only: 0 = acknowledge in read cycle, 1 = in write cycle |
| ack_high | input | 1 | Acknowledge polarity: 0 active-low, 1 active-high |
| rd_strobe | input | 1 | Read cycle in progress |
| wr_strobe | input | 1 | Write cycle in progress |
| xfer_done | input | 1 | Single-cycle pulse: one transfer completed |
| err_clr | input | 1 | Request to clear the sticky error flag |
| src_ld | input | 1 | Load the source address |
| src_ld_val | input | AW | Source load value |
| dst_ld | input | 1 | Load the destination address |
| dst_ld_val | input | AW | Destination load value |
| src_addr | output | AW | Current source address |
| dst_addr | output | AW | Current destination address |
| ack | output | 1 | Acknowledge toward the external device |
| cfg_err | output | 1 | Sticky illegal-setting flag |

## Verification
The hardest state to reach from the ports is a sticky error followed by a config that has since become legal. At that point a transfer-done pulse must still leave both addresses alone. Clearing is equally hard: it must fail while the illegal setting is still present. The bench gets there for every illegal combination. It sweeps all units, both mode fields, both address modes and both choices of external side. Whenever a combination sets the flag, the bench switches to a legal setting and pulses transfer-done again. Each sweep step starts with addresses near the top of the address space and near zero, so both upward and downward wrap are exercised.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [1:0] {
    AM_HOLD = 2'b00,
    AM_UP   = 2'b01,
    AM_DOWN = 2'b10,
    AM_RSVD = 2'b11
  } addr_mode_e;

  typedef enum logic [1:0] {
    UNIT_B1  = 2'b00,
    UNIT_B2  = 2'b01,
    UNIT_B4  = 2'b10,
    UNIT_B16 = 2'b11
  } unit_e;

  localparam int N_SIDES  = 2;
  localparam int SIDE_SRC = 0;
  localparam int SIDE_DST = 1;
  localparam int STEP_W   = 5;

  // byte distance moved per transfer for a unit size
  function automatic logic [STEP_W-1:0] unit_step(unit_e u);
    return STEP_W'(1) << (u == UNIT_B16 ? 3'd4 : {1'b0, u});
  endfunction

  // a mode/unit pairing that must not be used
  function automatic logic mode_bad(addr_mode_e m, unit_e u);
    return (m == AM_RSVD) || ((u == UNIT_B16) && (m != AM_UP));
  endfunction

endpackage

// File: rtl/dma_addr_reg.sv
module dma_addr_reg
  import dma_seq_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          upd,
  input  addr_mode_e    mode,
  input  unit_e         unit,
  output logic [AW-1:0] addr
);

  logic [AW-1:0] step_w;
  logic [AW-1:0] nxt;

  assign step_w = AW'(unit_step(unit));

  always_comb begin
    nxt = addr;
    if (load) begin
      nxt = load_val;
    end else if (upd) begin
      case (mode)
        AM_UP:   nxt = addr + step_w;
        AM_DOWN: nxt = addr - step_w;
        default: nxt = addr;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr <= '0;
    else        addr <= nxt;
  end

  // R6/R1: nothing moves without a load or an update
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !upd) |=> (addr == $past(addr)));

  // R11: a load wins over an update
  p_load_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (addr == $past(load_val)));

  // R1: hold mode leaves the address alone on an update
  p_hold_mode_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !load && mode == AM_HOLD) |=> (addr == $past(addr)));

endmodule

// File: rtl/dma_cfg_check.sv
module dma_cfg_check
  import dma_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  addr_mode_e         src_mode,
  input  addr_mode_e         dst_mode,
  input  unit_e              unit,
  input  logic               single_mode,
  input  logic               ext_on_dst,
  input  logic               err_clr,
  output logic [N_SIDES-1:0] side_used,
  output logic               illegal,
  output logic               err
);

  logic [N_SIDES-1:0] side_bad;

  // in single mode the external side is not addressed at all
  assign side_used[SIDE_SRC] = !(single_mode && !ext_on_dst);
  assign side_used[SIDE_DST] = !(single_mode &&  ext_on_dst);

  assign side_bad[SIDE_SRC] = mode_bad(src_mode, unit);
  assign side_bad[SIDE_DST] = mode_bad(dst_mode, unit);

  assign illegal = |(side_used & side_bad);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err <= 1'b0;
    else if (illegal) err <= 1'b1;
    else if (err_clr) err <= 1'b0;
  end

  // R4: an illegal setting raises the flag
  p_flag_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> err);

  // R5: the flag stays until a clear request
  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !err_clr) |=> err);

  // R5: a clean config with no flag stays clean
  p_flag_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!err && !illegal) |=> !err);

  // R7: single mode always leaves exactly one side in use
  p_one_side_r7: assert property (@(posedge clk) disable iff (!rst_n)
    single_mode |-> ($countones(side_used) == 1));

endmodule

// File: rtl/dma_ack_gen.sv
module dma_ack_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic single_mode,
  input  logic ack_on_write,
  input  logic ack_high,
  input  logic rd_strobe,
  input  logic wr_strobe,
  output logic ack
);

  logic active;

  always_comb begin
    if (single_mode)       active = rd_strobe | wr_strobe;
    else if (ack_on_write) active = wr_strobe;
    else                   active = rd_strobe;
  end

  assign ack = ack_high ? active : !active;

  // R10: no cycle in progress means deasserted level
  p_idle_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_strobe && !wr_strobe) |-> (ack == !ack_high));

  // R9: single mode acknowledges any cycle
  p_single_any_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (single_mode && (rd_strobe || wr_strobe)) |-> (ack == ack_high));

  // R8: dual mode, write-cycle select ignores a lone read
  p_dual_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!single_mode && ack_on_write && rd_strobe && !wr_strobe) |-> (ack == !ack_high));

endmodule

// File: rtl/dma_addr_seq.sv
module dma_addr_seq
  import dma_seq_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    src_mode,
  input  logic [1:0]    dst_mode,
  input  logic [1:0]    unit_sel,
  input  logic          single_mode,
  input  logic          ext_on_dst,
  input  logic          ack_on_write,
  input  logic          ack_high,
  input  logic          rd_strobe,
  input  logic          wr_strobe,
  input  logic          xfer_done,
  input  logic          err_clr,
  input  logic          src_ld,
  input  logic [AW-1:0] src_ld_val,
  input  logic          dst_ld,
  input  logic [AW-1:0] dst_ld_val,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic          ack,
  output logic          cfg_err
);

  addr_mode_e                   side_mode [N_SIDES];
  unit_e                        unit;
  logic [N_SIDES-1:0]           side_used;
  logic [N_SIDES-1:0]           side_ld;
  logic [N_SIDES-1:0][AW-1:0]   side_ld_val;
  logic [N_SIDES-1:0][AW-1:0]   side_addr;
  logic                         illegal;
  logic                         go;

  assign side_mode[SIDE_SRC]   = addr_mode_e'(src_mode);
  assign side_mode[SIDE_DST]   = addr_mode_e'(dst_mode);
  assign unit                  = unit_e'(unit_sel);
  assign side_ld[SIDE_SRC]     = src_ld;
  assign side_ld[SIDE_DST]     = dst_ld;
  assign side_ld_val[SIDE_SRC] = src_ld_val;
  assign side_ld_val[SIDE_DST] = dst_ld_val;

  dma_cfg_check u_check (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_mode    (side_mode[SIDE_SRC]),
    .dst_mode    (side_mode[SIDE_DST]),
    .unit        (unit),
    .single_mode (single_mode),
    .ext_on_dst  (ext_on_dst),
    .err_clr     (err_clr),
    .side_used   (side_used),
    .illegal     (illegal),
    .err         (cfg_err)
  );

  assign go = xfer_done && !cfg_err && !illegal;

  for (genvar g = 0; g < N_SIDES; g++) begin : g_side
    dma_addr_reg #(.AW(AW)) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (side_ld[g]),
      .load_val (side_ld_val[g]),
      .upd      (go && side_used[g]),
      .mode     (side_mode[g]),
      .unit     (unit),
      .addr     (side_addr[g])
    );
  end

  assign src_addr = side_addr[SIDE_SRC];
  assign dst_addr = side_addr[SIDE_DST];

  dma_ack_gen u_ack (
    .clk          (clk),
    .rst_n        (rst_n),
    .single_mode  (single_mode),
    .ack_on_write (ack_on_write),
    .ack_high     (ack_high),
    .rd_strobe    (rd_strobe),
    .wr_strobe    (wr_strobe),
    .ack          (ack)
  );

  // R6: a raised flag freezes both addresses unless loaded
  p_err_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && !src_ld && !dst_ld) |=> ($stable(src_addr) && $stable(dst_addr)));

  // R7: the external side in single mode never moves
  p_ext_src_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (single_mode && !ext_on_dst && !src_ld) |=> $stable(src_addr));

  p_ext_dst_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (single_mode && ext_on_dst && !dst_ld) |=> $stable(dst_addr));

endmodule

// File: tb/dma_addr_seq_test.sv
`timescale 1ns/1ps
module dma_addr_seq_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  src_mode, dst_mode, unit_sel;
  logic        single_mode, ext_on_dst, ack_on_write, ack_high;
  logic        rd_strobe, wr_strobe, xfer_done, err_clr;
  logic        src_ld, dst_ld;
  logic [31:0] src_ld_val, dst_ld_val;
  logic [31:0] src_addr, dst_addr;
  logic        ack, cfg_err;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  dma_addr_seq #(.AW(32)) uut (
    .clk(clk), .rst_n(rst_n), .src_mode(src_mode), .dst_mode(dst_mode),
    .unit_sel(unit_sel), .single_mode(single_mode), .ext_on_dst(ext_on_dst),
    .ack_on_write(ack_on_write), .ack_high(ack_high), .rd_strobe(rd_strobe),
    .wr_strobe(wr_strobe), .xfer_done(xfer_done), .err_clr(err_clr),
    .src_ld(src_ld), .src_ld_val(src_ld_val), .dst_ld(dst_ld),
    .dst_ld_val(dst_ld_val), .src_addr(src_addr), .dst_addr(dst_addr),
    .ack(ack), .cfg_err(cfg_err)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic bad(logic [1:0] m, logic [1:0] u);
    return (m == 2'b11) || (u == 2'b11 && m != 2'b01);
  endfunction

  function automatic logic [31:0] moved(logic [31:0] a, logic [1:0] m, logic [1:0] u);
    logic [31:0] st = (u == 2'b11) ? 32'd16 : (32'd1 << u);
    if (m == 2'b01) return a + st;
    if (m == 2'b10) return a - st;
    return a;
  endfunction

  task automatic legal_cfg();
    src_mode = 2'b01; dst_mode = 2'b01; unit_sel = 2'b00;
    single_mode = 1'b0; ext_on_dst = 1'b0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    legal_cfg();
    src_mode = 2'b00; dst_mode = 2'b00;
    ack_on_write = 1'b0; ack_high = 1'b0;
    rd_strobe = 1'b0; wr_strobe = 1'b0; xfer_done = 1'b0; err_clr = 1'b0;
    src_ld = 1'b0; dst_ld = 1'b0; src_ld_val = '0; dst_ld_val = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 src reset", src_addr, 32'h0);
    chk("R12 dst reset", dst_addr, 32'h0);
    chk("R12 err reset", {31'b0, cfg_err}, 32'h0);
    chk("R10 idle ack low-active", {31'b0, ack}, 32'h1);

    // full sweep of unit, modes, address mode and external side
    for (int idx = 0; idx < 256; idx++) begin
      logic [1:0]  u  = idx[1:0];
      logic [1:0]  sm = idx[3:2];
      logic [1:0]  dm = idx[5:4];
      logic        sg = idx[6];
      logic        ed = idx[7];
      logic        s_used = !(sg && !ed);
      logic        d_used = !(sg && ed);
      logic        ill = (s_used && bad(sm, u)) || (d_used && bad(dm, u));
      logic [31:0] s0 = 32'hFFFF_FFF0 + {28'h0, idx[3:0]};
      logic [31:0] d0 = {24'h0, idx[7:4], 4'h0} + {28'h0, idx[3:0]};
      logic [31:0] s_exp = (s_used && !ill) ? moved(s0, sm, u) : s0;
      logic [31:0] d_exp = (d_used && !ill) ? moved(d0, dm, u) : d0;
      // restore a legal setup, clear the flag, load both addresses
      legal_cfg();
      err_clr = 1'b1;
      src_ld = 1'b1; src_ld_val = s0;
      dst_ld = 1'b1; dst_ld_val = d0;
      tick();
      err_clr = 1'b0; src_ld = 1'b0; dst_ld = 1'b0;
      src_mode = sm; dst_mode = dm; unit_sel = u;
      single_mode = sg; ext_on_dst = ed;
      xfer_done = 1'b1;
      tick();
      xfer_done = 1'b0;
      chk("R1/R2/R3/R7 src step", src_addr, s_exp);
      chk("R1/R2/R3/R7 dst step", dst_addr, d_exp);
      chk("R4 flag after step", {31'b0, cfg_err}, {31'b0, ill});
      if (ill) begin
        // flag set, setting now legal: transfer must still not move anything
        legal_cfg();
        xfer_done = 1'b1;
        tick();
        xfer_done = 1'b0;
        chk("R6 src frozen by flag", src_addr, s0);
        chk("R6 dst frozen by flag", dst_addr, d0);
        chk("R5 flag sticky", {31'b0, cfg_err}, 32'h1);
      end
    end

    // R5: clear refused while a setting is still illegal, then accepted
    legal_cfg();
    src_mode = 2'b11;
    tick();
    err_clr = 1'b1;
    tick();
    chk("R5 clear loses to illegal", {31'b0, cfg_err}, 32'h1);
    legal_cfg();
    tick();
    err_clr = 1'b0;
    chk("R5 clear with legal setup", {31'b0, cfg_err}, 32'h0);

    // R11: load and transfer in the same cycle, load wins; load works under flag
    src_ld = 1'b1; src_ld_val = 32'h1234_5678;
    xfer_done = 1'b1;
    tick();
    src_ld = 1'b0; xfer_done = 1'b0;
    chk("R11 load beats update", src_addr, 32'h1234_5678);
    dst_mode = 2'b11;
    tick();
    dst_ld = 1'b1; dst_ld_val = 32'hCAFE_0000;
    tick();
    dst_ld = 1'b0;
    chk("R11 load under flag", dst_addr, 32'hCAFE_0000);
    legal_cfg();
    err_clr = 1'b1;
    tick();
    err_clr = 1'b0;

    // acknowledge sweep: address mode x cycle select x level x strobes
    for (int k = 0; k < 32; k++) begin
      logic act, exp_ack;
      single_mode  = k[0];
      ack_on_write = k[1];
      ack_high     = k[2];
      rd_strobe    = k[3];
      wr_strobe    = k[4];
      #1;
      act = single_mode ? (rd_strobe | wr_strobe)
                        : (ack_on_write ? wr_strobe : rd_strobe);
      exp_ack = ack_high ? act : !act;
      if (single_mode) chk("R9/R10 single ack", {31'b0, ack}, {31'b0, exp_ack});
      else             chk("R8/R10 dual ack",   {31'b0, ack}, {31'b0, exp_ack});
      @(negedge clk);
    end
    rd_strobe = 1'b0; wr_strobe = 1'b0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule